// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous, idle-high serial line into parallel characters. The line is brought into the clock domain through a two-flop synchronizer. A one-cycle tick that runs at sixteen times the bit rate paces it. The receiver arms on a falling edge of the line. It confirms the start bit at its middle, so that a short low-going noise spike is discarded and assembles nothing. It then samples each data bit, the optional parity bit and one stop bit at the middle of that bit.

A finished character is placed in an output holding register and `char_valid` is raised. The consumer takes the character with `char_ack`. Each character carries three flags: parity error, framing error and line break. A line held low through the whole frame counts as a break, and the receiver then waits for the line to return high before it can arm again. When a character completes before the consumer has taken the previous one, a sticky overrun flag is raised. It stays set until `ovr_clr` is pulsed.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `char_valid`, `char_data`, `err_parity`, `err_frame`, `err_break` and `ovr_flag` are all zero, and the synchronized line is taken as high.
- R2: Reception is armed only by a high-to-low change of the synchronized line between two consecutive ticks. On the 8th tick after arming the line is checked again, and if it is high the receiver returns to idle without producing a character.
- R3: `len_sel` selects the character length as 5 + `len_sel` (00=5, 01=6, 10=7, 11=8 bits). Bits arrive LSB first. The character is right-justified in `char_data`, and the bits above the length read as zero.
- R4: `par_mode` bit 0 enables a parity bit after the data bits. Bit 1 selects even parity (1) or odd parity (0). `err_parity` is set when the received parity bit differs from the one computed over the data bits: for even parity the XOR of the data, for odd parity its inverse.
- R5: `err_frame` is set when the stop-bit position is sampled low.
- R6: When the data bits, the parity bit (if enabled) and the stop bit are all sampled low, the character is reported with `err_break`=1, `err_frame`=1, `err_parity`=0 and data zero. No new start is accepted until the line has been sampled high on a tick.
- R7: `char_valid` rises in the clock cycle in which the stop bit is sampled. It stays high until a cycle with `char_ack`=1 and no new character, after which it is low.
- R8: `ovr_flag` is set when a character completes while `char_valid` is high and `char_ack` is low. It then holds until a cycle with `ovr_clr`=1 and no new overrun.
- R9: Counting ticks from the one that armed reception (tick 0), bit k after the start bit (k = 0 for the first data bit) is sampled on tick 24 + 16k. The line reaches the sampler two clock cycles after `rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Character length select (5 + value) |
| par_mode | input | 2 | Bit 0 parity enable, bit 1 even select |
| char_ack | input | 1 | Consumer takes the held character |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| char_data | output | 8 | Received character, right-justified |
| char_valid | output | 1 | A character is held |
| err_parity | output | 1 | Parity error of held character |
| err_frame | output | 1 | Framing error of held character |
| err_break | output | 1 | Held character is a line break |
| ovr_flag | output | 1 | Sticky overrun |

## Verification
A wrong tick counter or sample point shows up as a character with shifted or missing bits. It appears on `char_valid` at most one bit period late, so the per-clock model comparison flags it at the stop edge of the first frame. A wrong start-check state shows up as a spurious character after the noise-spike stimulus. It surfaces within about ten bit periods. A lost break-wait state shows up as an extra character while the line is still held low. Mistakes in the holding register show up on the very clock edge of the acknowledge or of the second unacknowledged completion, and this applies to both `char_valid` and `ovr_flag`.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4,
    RX_BRK   = 3'd5
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_result_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  input  logic [1:0]       len_sel,
  input  logic [1:0]       par_mode,
  output logic             done,
  output rx_result_t       result
);
  localparam int CNT_W   = $clog2(OSR);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  shr_q, shr_d;
  logic               par_q, par_d;
  logic               prev_q, prev_d;

  logic [IDX_W-1:0]   last_idx;
  logic               par_en;
  logic               exp_par;
  logic               is_brk;

  assign last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(len_sel);
  assign par_en   = par_mode[0];
  assign exp_par  = par_mode[1] ? (^shr_q) : ~(^shr_q);
  assign is_brk   = (shr_q == '0) && (!par_en || !par_q) && !rx;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    par_d   = par_q;
    prev_d  = tick ? rx : prev_q;
    done    = 1'b0;
    if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (prev_q && !rx) begin
            state_d = RX_START;
            cnt_d   = '0;
            shr_d   = '0;
            par_d   = 1'b0;
          end
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_d   = '0;
            idx_d   = '0;
            state_d = rx ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d        = '0;
            shr_d[idx_q] = rx;
            if (idx_q == last_idx) state_d = par_en ? RX_PAR : RX_STOP;
            else                   idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            par_d   = rx;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            done    = 1'b1;
            state_d = is_brk ? RX_BRK : RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_BRK: begin
          if (rx) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_comb begin
    result.data = shr_q;
    result.brk  = is_brk;
    result.ferr = !rx;
    result.perr = par_en && !is_brk && (par_q != exp_par);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
      par_q   <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      par_q   <= par_d;
      prev_q  <= prev_d;
    end
  end
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  rx_result_t result,
  input  logic       ack,
  input  logic       ovr_clr,
  output rx_result_t held,
  output logic       valid,
  output logic       ovr
);
  rx_result_t held_q, held_d;
  logic       valid_q, valid_d;
  logic       ovr_q, ovr_d;

  always_comb begin
    held_d  = done ? result : held_q;
    valid_d = done ? 1'b1 : (ack ? 1'b0 : valid_q);
    if (done && valid_q && !ack) ovr_d = 1'b1;
    else if (ovr_clr)            ovr_d = 1'b0;
    else                         ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      held_q  <= held_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  assign held  = held_q;
  assign valid = valid_q;
  assign ovr   = ovr_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_mode,
  input  logic       char_ack,
  input  logic       ovr_clr,
  output logic [7:0] char_data,
  output logic       char_valid,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_break,
  output logic       ovr_flag
);
  logic       rx_s;
  logic       char_done;
  rx_result_t frame_res;
  rx_result_t held_res;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_s)
  );

  serial_rx_frame #(.OSR(OSR), .DATA_W(8)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_16x),
    .rx      (rx_s),
    .len_sel (len_sel),
    .par_mode(par_mode),
    .done    (char_done),
    .result  (frame_res)
  );

  serial_rx_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (char_done),
    .result (frame_res),
    .ack    (char_ack),
    .ovr_clr(ovr_clr),
    .held   (held_res),
    .valid  (char_valid),
    .ovr    (ovr_flag)
  );

  assign char_data  = held_res.data;
  assign err_parity = held_res.perr;
  assign err_frame  = held_res.ferr;
  assign err_break  = held_res.brk;
endmodule

// File: rtl/serial_rx_core_sva.sv
module serial_rx_core_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       char_done,
  input logic       char_ack,
  input logic       ovr_clr,
  input logic       char_valid,
  input logic [7:0] char_data,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_break,
  input logic       ovr_flag
);
  AST_VALID_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> char_valid); // R7
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ack) |=> char_valid); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_ack && !char_done) |=> !char_valid); // R7
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && char_valid && !char_ack) |=> ovr_flag); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag); // R8
  AST_BRK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && err_break) |-> (err_frame && !err_parity && char_data == 8'h00)); // R6
endmodule

bind serial_rx_core serial_rx_core_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .char_done (char_done),
  .char_ack  (char_ack),
  .ovr_clr   (ovr_clr),
  .char_valid(char_valid),
  .char_data (char_data),
  .err_parity(err_parity),
  .err_frame (err_frame),
  .err_break (err_break),
  .ovr_flag  (ovr_flag)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic [1:0] par_mode = 2'b00;
  logic       char_ack = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [7:0] char_data;
  logic       char_valid, err_parity, err_frame, err_break, ovr_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd(rxd),
    .len_sel(len_sel), .par_mode(par_mode), .char_ack(char_ack),
    .ovr_clr(ovr_clr), .char_data(char_data), .char_valid(char_valid),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .ovr_flag(ovr_flag)
  );

  always #2.5 clk = ~clk;

  // tick generator, driven away from the active edge
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick_16x <= (tdiv == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int sq[$];
  int m_ph, m_tk, m_nb, m_got, m_shr, m_par, m_prev, m_brkwait;
  int e_valid, e_data, e_pe, e_fe, e_brk, e_ovr;

  always @(posedge clk) begin
    int rx, done, d_data, d_pe, d_fe, d_brk, ones, pen;
    if (!rst_n) begin
      sq = '{1, 1};
      m_ph = 0; m_tk = 0; m_got = 0; m_shr = 0; m_par = 0; m_prev = 1;
      m_brkwait = 0;
      e_valid = 0; e_data = 0; e_pe = 0; e_fe = 0; e_brk = 0; e_ovr = 0;
    end else begin
      rx = sq[0];
      pen = par_mode[0];
      m_nb = 5 + int'(len_sel);
      done = 0; d_data = 0; d_pe = 0; d_fe = 0; d_brk = 0;
      if (tick_16x) begin
        if (m_brkwait) begin
          if (rx == 1) m_brkwait = 0;
        end else if (m_ph == 0) begin
          if (m_prev == 1 && rx == 0) begin
            m_ph = 1; m_tk = 0; m_got = 0; m_shr = 0; m_par = 0;
          end
        end else begin
          m_tk++;
          if (m_ph == 1 && m_tk == 8) begin
            if (rx == 1) m_ph = 0;
            else begin m_ph = 2; m_tk = 0; end
          end else if (m_ph == 2 && m_tk == 16) begin
            m_tk = 0;
            if (m_got < m_nb) begin
              m_shr = m_shr | (rx << m_got);
              m_got++;
            end else if (pen && m_got == m_nb) begin
              m_par = rx;
              m_got++;
            end else begin
              ones = $countones(m_shr);
              d_brk = (m_shr == 0 && (!pen || m_par == 0) && rx == 0);
              d_data = m_shr;
              d_fe = (rx == 0);
              d_pe = pen && !d_brk &&
                     (m_par != (par_mode[1] ? (ones % 2) : 1 - (ones % 2)));
              done = 1;
              m_ph = 0;
              m_brkwait = d_brk;
            end
          end
        end
        m_prev = rx;
      end
      if (done && e_valid && !char_ack) e_ovr = 1;
      else if (ovr_clr) e_ovr = 0;
      if (done) begin
        e_valid = 1; e_data = d_data; e_pe = d_pe; e_fe = d_fe; e_brk = d_brk;
      end else if (char_ack) e_valid = 0;
      void'(sq.pop_front());
      sq.push_back(int'(rxd));
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 valid", char_valid, e_valid);
      chk("R3 data", char_data, e_data);
      chk("R4 parity", err_parity, e_pe);
      chk("R5 frame", err_frame, e_fe);
      chk("R6 break", err_break, e_brk);
      chk("R8 overrun", ovr_flag, e_ovr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic hold_line(input logic v, input int nclk);
    rxd <= v;
    repeat (nclk) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par, input logic stop_v);
    int nb;
    logic p;
    nb = 5 + int'(len_sel);
    p = 1'b0;
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) begin
      p = p ^ d[i];
      hold_line(d[i], BIT_CLKS);
    end
    if (par_mode[0]) hold_line((par_mode[1] ? p : ~p) ^ flip_par, BIT_CLKS);
    hold_line(stop_v, BIT_CLKS);
    hold_line(1'b1, BIT_CLKS);
  endtask

  task automatic pulse_ack();
    char_ack <= 1'b1; @(negedge clk);
    char_ack <= 1'b0; @(negedge clk);
  endtask

  task automatic expect_char(input string tag, input int d, input int pe,
                             input int fe, input int bk);
    chk({tag, " valid"}, char_valid, 1);
    chk({tag, " data"}, char_data, d);
    chk({tag, " perr"}, err_parity, pe);
    chk({tag, " ferr"}, err_frame, fe);
    chk({tag, " brk"}, err_break, bk);
    pulse_ack();
    chk("R7 ack clears valid", char_valid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset valid", char_valid, 0);
    chk("R1 reset data", char_data, 0);
    chk("R1 reset ovr", ovr_flag, 0);
    rst_n <= 1'b1;
    hold_line(1'b1, 3 * BIT_CLKS);

    // R3: 8-bit, LSB first, no parity
    len_sel = 2'b11; par_mode = 2'b00;
    send(8'hA5, 0, 1'b1);
    expect_char("R3 len8", 8'hA5, 0, 0, 0);
    // R3: 5-bit right justified, upper zero
    len_sel = 2'b00;
    send(8'hFB, 0, 1'b1);
    expect_char("R3 len5", 8'h1B, 0, 0, 0);
    len_sel = 2'b01;
    send(8'h2D, 0, 1'b1);
    expect_char("R3 len6", 8'h2D, 0, 0, 0);
    // R4: 7-bit even parity good then bad
    len_sel = 2'b10; par_mode = 2'b11;
    send(8'h53, 0, 1'b1);
    expect_char("R4 even ok", 8'h53, 0, 0, 0);
    send(8'h53, 1, 1'b1);
    expect_char("R4 even bad", 8'h53, 1, 0, 0);
    // R4: odd parity
    len_sel = 2'b11; par_mode = 2'b01;
    send(8'h0F, 0, 1'b1);
    expect_char("R4 odd ok", 8'h0F, 0, 0, 0);
    send(8'h0F, 1, 1'b1);
    expect_char("R4 odd bad", 8'h0F, 1, 0, 0);
    // R5: framing error
    par_mode = 2'b00;
    send(8'h55, 0, 1'b0);
    expect_char("R5 frame", 8'h55, 0, 1, 0);
    // R2: noise spike of two ticks, no character
    hold_line(1'b0, 2 * TICK_DIV);
    hold_line(1'b1, 12 * BIT_CLKS);
    chk("R2 spike ignored", char_valid, 0);
    send(8'h3C, 0, 1'b1);
    expect_char("R2 after spike", 8'h3C, 0, 0, 0);
    // R6: break, line held low well past frame
    hold_line(1'b0, 12 * BIT_CLKS);
    expect_char("R6 break", 0, 0, 1, 1);
    hold_line(1'b0, 12 * BIT_CLKS);
    chk("R6 no restart while low", char_valid, 0);
    hold_line(1'b1, 2 * BIT_CLKS);
    send(8'h81, 0, 1'b1);
    expect_char("R6 after break", 8'h81, 0, 0, 0);
    // R8: overrun
    send(8'h11, 0, 1'b1);
    chk("R8 no ovr yet", ovr_flag, 0);
    send(8'h22, 0, 1'b1);
    chk("R8 ovr set", ovr_flag, 1);
    chk("R8 newest kept", char_data, 8'h22);
    pulse_ack();
    chk("R8 ovr sticky after ack", ovr_flag, 1);
    ovr_clr <= 1'b1; @(negedge clk);
    ovr_clr <= 1'b0; @(negedge clk);
    chk("R8 ovr cleared", ovr_flag, 0);
    // R9: timing is covered by the per-clock model; one more frame
    send(8'hC3, 0, 1'b1);
    expect_char("R9 final", 8'hC3, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule